// File: doc/BRIEF.md
# Two-Wire Bus Link Monitor

This block watches the data and clock lines of a two-wire serial bus and tells software when the bus has been plugged in or pulled out. The bus counts as up when both lines sit high and as down when both sit low. A change of state is only accepted once the new level pair has stayed unchanged for a programmable settle time, so contact bounce while a connector is mated or removed is filtered out. Each accepted change is reported once. The next report waits until the opposite state has itself settled.

A single 8-bit control/status register holds an event flag, a local interrupt enable, a settle-time code and a direction bit. The direction bit chooses whether bus-up or bus-down changes raise the flag. An interrupt request is driven while the flag, the local enable and a global enable are all set. Software clears the flag by writing a one to it, and the interrupt acknowledge pulse also clears it.

During reset the flag is loaded from the raw lines. If both are high the flag comes out of reset already set. Detection runs only while the peripheral-enable input is high.

Top module: `twbus_link_monitor`

## Requirements
- R1: Register layout as read on `reg_rdata`: bit 7 is the flag, bit 6 is the interrupt enable, bits 2:1 are the settle code and bit 0 is the direction bit. Bits 5:3 always read zero. Enable, code and direction take `reg_wdata` on a write and reset to zero.
- R2: Out of reset the flag is one when both raw lines are high at reset, and zero otherwise.
- R3: With direction bit 0, only a settled bus-up change sets the flag. With direction bit 1, only a settled bus-down change sets it.
- R4: A write with bit 7 set clears the flag. A write with bit 7 clear leaves the flag unchanged.
- R5: A one-cycle pulse on `irq_ack` clears the flag.
- R6: `irq_req` is high exactly when `glb_irq_en`, the interrupt enable and the flag are all one.
- R7: A change settles after the new level pair (both high or both low) has been held for 100, 200, 400 or 800 cycles, for settle codes 0 to 3. The lines pass through a two-flop synchronizer first. Any change of either line restarts the count.
- R8: While `periph_en` is low, no change is detected and the flag is not set. Once it returns high, a pending level is detected after a full settle time.
- R9: A bus state that stays put sets the flag once only. The same kind of change can set it again only after the opposite state has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sda_raw | input | 1 | Raw data line level |
| scl_raw | input | 1 | Raw clock line level |
| periph_en | input | 1 | Enables detection |
| glb_irq_en | input | 1 | Global interrupt enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears flag |
| reg_rdata | output | 8 | Register contents |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- an accepted change always sits on a matching level pair that was already present one cycle earlier;
- a change is never reported on two cycles in a row;
- the flag rises only on a selected change;
- the write-one-to-clear, write-zero-to-keep and acknowledge rules are honoured;
- the interrupt request never appears without all three enables.

Only the bench's scenarios can show the following:
- the exact settle lengths for each code;
- the restart of the count after a short glitch;
- the one-shot behaviour over long stable periods;
- the reset value taken from the lines;
- the quiet period while detection is disabled.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic {
    BUS_DOWN = 1'b0,
    BUS_UP   = 1'b1
  } bus_state_e;

  // Settle length in cycles for a 2-bit code: base doubled per code step.
  function automatic int unsigned settle_cycles(input logic [1:0] code,
                                                input int unsigned base);
    return base << code;
  endfunction

endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk) begin
      if (!rst_n) shreg <= {STAGES{din[i]}};
      else        shreg <= {shreg[STAGES-2:0], din[i]};
    end
    assign dout[i] = shreg[STAGES-1];
  end

endmodule

// File: rtl/twb_settle_tracker.sv
module twb_settle_tracker
  import twb_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_up,
  input  logic [1:0] pair,
  input  logic       enable,
  input  logic [1:0] code,
  output logic       evt_up,
  output logic       evt_down
);

  localparam int unsigned MAX_LEN = BASE_CYCLES * 8;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] RUN_SAT = CW'(MAX_LEN);

  logic [1:0]    prev_q;
  logic [CW-1:0] run_q;
  bus_state_e    state_q;
  logic          same;
  logic [CW-1:0] lim_m1;
  logic          held;

  assign same   = (pair == prev_q);
  assign lim_m1 = CW'(settle_cycles(code, BASE_CYCLES) - 1);
  assign held   = enable && same && (run_q >= lim_m1);

  assign evt_up   = held && (pair == 2'b11) && (state_q == BUS_DOWN);
  assign evt_down = held && (pair == 2'b00) && (state_q == BUS_UP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= init_up ? 2'b11 : 2'b00;
      run_q   <= '0;
      state_q <= init_up ? BUS_UP : BUS_DOWN;
    end else begin
      prev_q <= pair;
      if (!enable || !same)    run_q <= '0;
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
      if (evt_up)        state_q <= BUS_UP;
      else if (evt_down) state_q <= BUS_DOWN;
    end
  end

  AST_UP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_up |-> (pair == 2'b11 && $past(pair) == 2'b11)); // R7
  AST_DOWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_down |-> (pair == 2'b00 && $past(pair) == 2'b00)); // R7
  AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_up || evt_down) |=> !(evt_up || evt_down)); // R9

endmodule

// File: rtl/twb_ctrl_reg.sv
module twb_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_flag,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       ack,
  input  logic       set_evt,
  input  logic       glb_en,
  output logic [7:0] rdata,
  output logic [1:0] code,
  output logic       dir,
  output logic       irq
);

  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT   = 6;

  logic       flag_q;
  logic       ie_q;
  logic [1:0] code_q;
  logic       dir_q;
  logic       clr_req;
  logic       rsvd_unused;

  assign rsvd_unused = ^wdata[5:3];
  assign clr_req     = (wr_en && wdata[FLAG_BIT]) || ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= init_flag;
      ie_q   <= 1'b0;
      code_q <= 2'b00;
      dir_q  <= 1'b0;
    end else begin
      // A fresh event outranks a clear in the same cycle.
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wr_en) begin
        ie_q   <= wdata[IE_BIT];
        code_q <= wdata[2:1];
        dir_q  <= wdata[0];
      end
    end
  end

  assign rdata = {flag_q, ie_q, 3'b000, code_q, dir_q};
  assign code  = code_q;
  assign dir   = dir_q;
  assign irq   = glb_en && ie_q && flag_q;

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[FLAG_BIT] && !set_evt) |=> !flag_q); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[FLAG_BIT] && !ack && flag_q) |=> flag_q); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_evt) |=> !flag_q); // R5
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R3

endmodule

// File: rtl/twbus_link_monitor.sv
module twbus_link_monitor #(
  parameter int unsigned BASE_CYCLES = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_raw,
  input  logic       scl_raw,
  input  logic       periph_en,
  input  logic       glb_irq_en,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wdata,
  input  logic       irq_ack,
  output logic [7:0] reg_rdata,
  output logic       irq_req
);

  logic [1:0] pair_s;
  logic       lines_up;
  logic       evt_up;
  logic       evt_down;
  logic       set_evt;
  logic [1:0] code;
  logic       dir;

  assign lines_up = sda_raw && scl_raw;

  twb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sda_raw, scl_raw}),
    .dout (pair_s)
  );

  twb_settle_tracker #(.BASE_CYCLES(BASE_CYCLES)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_up (lines_up),
    .pair    (pair_s),
    .enable  (periph_en),
    .code    (code),
    .evt_up  (evt_up),
    .evt_down(evt_down)
  );

  // Direction bit 0 reports bus-up changes, 1 reports bus-down changes.
  assign set_evt = dir ? evt_down : evt_up;

  twb_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_flag(lines_up),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .ack      (irq_ack),
    .set_evt  (set_evt),
    .glb_en   (glb_irq_en),
    .rdata    (reg_rdata),
    .code     (code),
    .dir      (dir),
    .irq      (irq_req)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (glb_irq_en && reg_rdata[7] && reg_rdata[6])); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_en && !reg_rdata[7]) |=> !reg_rdata[7]); // R8

endmodule

// File: tb/twbus_link_monitor_bench.sv
module twbus_link_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda_raw = 1'b1;
  logic       scl_raw = 1'b1;
  logic       periph_en = 1'b1;
  logic       glb_irq_en = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       irq_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twbus_link_monitor u_twbus_link_monitor (
    .clk(clk), .rst_n(rst_n), .sda_raw(sda_raw), .scl_raw(scl_raw),
    .periph_en(periph_en), .glb_irq_en(glb_irq_en), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .irq_ack(irq_ack), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lines(input logic up);
    sda_raw = up;
    scl_raw = up;
  endtask

  task automatic do_reset(input logic sda, input logic scl);
    @(negedge clk);
    rst_n = 1'b0;
    sda_raw = sda;
    scl_raw = scl;
    idle(5);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = 8'h00;
    idle(1);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    idle(1);
  endtask

  task automatic t_reset_up();
    do_reset(1'b1, 1'b1);
    chk("R2 R1 reset lines high", reg_rdata, 8'h80);
    chk("R6 no irq with enables clear", {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_reset_down();
    do_reset(1'b1, 1'b0);
    chk("R2 reset one line low", reg_rdata, 8'h00);
  endtask

  task automatic t_reg_fields();
    wr(8'hFF);
    chk("R1 writable fields, bits 5:3 zero", reg_rdata, 8'h47);
    wr(8'h00);
    chk("R1 fields cleared", reg_rdata, 8'h00);
  endtask

  task automatic t_connect_basic();
    wr(8'h40);
    set_lines(1'b1);
    idle(90);
    chk("R7 no flag before 100 cycles", reg_rdata, 8'h40);
    idle(20);
    chk("R3 R7 bus-up sets flag", reg_rdata, 8'hC0);
    chk("R6 irq blocked by global enable", {7'd0, irq_req}, 8'h00);
    glb_irq_en = 1'b1;
    idle(1);
    chk("R6 irq with all enables", {7'd0, irq_req}, 8'h01);
    wr(8'h40);
    chk("R4 write zero keeps flag", reg_rdata, 8'hC0);
    ack_pulse();
    chk("R5 ack clears flag", reg_rdata, 8'h40);
    chk("R6 irq drops with flag", {7'd0, irq_req}, 8'h00);
    idle(1000);
    chk("R9 steady bus-up does not re-raise", reg_rdata, 8'h40);
  endtask

  task automatic t_rearm();
    set_lines(1'b0);
    idle(300);
    chk("R3 bus-down ignored with direction 0", reg_rdata, 8'h40);
    set_lines(1'b1);
    idle(90);
    chk("R9 re-raise waits for settle", reg_rdata, 8'h40);
    idle(20);
    chk("R9 re-raised after opposite state", reg_rdata, 8'hC0);
    wr(8'hC0);
    chk("R4 write one clears flag", reg_rdata, 8'h40);
  endtask

  task automatic t_disconnect_slow();
    wr(8'h45);
    chk("R1 code 2 direction 1", reg_rdata, 8'h45);
    set_lines(1'b0);
    idle(390);
    chk("R7 no flag before 400 cycles", reg_rdata, 8'h45);
    idle(20);
    chk("R3 R7 bus-down sets flag", reg_rdata, 8'hC5);
    wr(8'hC5);
    chk("R4 cleared before glitch test", reg_rdata, 8'h45);
  endtask

  task automatic t_glitch_restart();
    set_lines(1'b1);
    idle(500);
    chk("R3 bus-up ignored with direction 1", reg_rdata, 8'h45);
    set_lines(1'b0);
    idle(200);
    set_lines(1'b1);
    idle(3);
    set_lines(1'b0);
    idle(390);
    chk("R7 glitch restarted count", reg_rdata, 8'h45);
    idle(20);
    chk("R7 flag after restarted count", reg_rdata, 8'hC5);
    wr(8'hC5);
  endtask

  task automatic t_disabled();
    periph_en = 1'b0;
    wr(8'h40);
    set_lines(1'b1);
    idle(1000);
    chk("R8 no event while disabled", reg_rdata, 8'h40);
    periph_en = 1'b1;
    idle(90);
    chk("R8 full settle after enable", reg_rdata, 8'h40);
    idle(20);
    chk("R8 event after enable", reg_rdata, 8'hC0);
  endtask

  initial begin
    t_reset_up();
    t_reset_down();
    t_reg_fields();
    t_connect_basic();
    t_rearm();
    t_disconnect_slow();
    t_glitch_restart();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule